// File: doc/BRIEF.md
# GPIO Pad Controller with Per-Pad Function Select

This block drives a bank of general-purpose pads from a small register bus. Every pad owns a seven-bit setup word. The word picks which of eight sources drives the pad and sets four controls: invert, pull-up, pull-down and output direction. Sources 0 to 6 are alternate functions that sit next to the pad. Each supplies a data bit and an output-enable bit. Source 7 is plain GPIO, where the pad level comes from an output latch owned by software. Software never rewrites that latch directly. It writes ones into a "raise" word to drive pads high and ones into a "drop" word to drive them low, so two agents can change different pads without a read-modify-write.

Pad input levels pass through a two-stage synchronizer. After that they are visible in 32-bit input words and on a per-pad feed to the alternate functions. Both copies take the pad's invert setting into account.

The block keeps no sequencing state. Each bus access is sorted by a decoder into one named region: `RG_CFG` (pad setup word), `RG_DIN` (input word, read only), `RG_SET` (raise word), `RG_CLR` (drop word), `RG_DOUT` (output latch readback) or `RG_NONE` (unmapped). Writes act on the clock edge. Reads are combinational from the current address.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset every pad setup word reads 0x07 (GPIO, input, no pulls, no invert), all output latch bits are 0, and `pad_oe`, `pad_out`, `pad_pu` and `pad_pd` are all zero.
- R2: Addresses 0x00 to NUM_PADS-1 hold the pad setup words. The word layout is bits [2:0] source select, bit 3 direction (1 = drive), bit 4 pull-down, bit 5 pull-up and bit 6 invert. A write stores bits [6:0], and a read returns them with bits [31:7] zero.
- R3: When source select is 0 to 6, `pad_out[p]` and `pad_oe[p]` follow `alt_dout[p*7+m]` and `alt_oe[p*7+m]` for the selected source m.
- R4: When source select is 7, `pad_out[p]` follows output latch bit p and `pad_oe[p]` equals the direction bit.
- R5: Writing to raise word w (address 0x90+w) sets every latch bit 32*w+k whose data bit k is 1. Latch bits whose data bit is 0 keep their value.
- R6: Writing to drop word w (address 0xA0+w) clears every latch bit 32*w+k whose data bit k is 1. Latch bits whose data bit is 0 keep their value.
- R7: The invert bit flips the pad's output level in every source mode. It also flips the pad's input level as seen in the input words and on `alt_din`.
- R8: `pad_pu[p]` follows the pull-up bit. `pad_pd[p]` follows the pull-down bit only while pull-up is 0, so both are never high together.
- R9: Input word w (address 0x80+w) bit k shows pad 32*w+k. A change on `pad_in` appears after the second rising clock edge and not after the first. Bits for pads at or above NUM_PADS read 0.
- R10: Writes to input words, to setup addresses at or above NUM_PADS, or to any unmapped address change no state. Unmapped reads return 0.
- R11: Output latch word w reads back at address 0xB0+w. Bits for pads at or above NUM_PADS stay 0 even after a raise write of all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| alt_dout | input | NUM_PADS*7 | Alternate function data, bit p*7+m for pad p, source m |
| alt_oe | input | NUM_PADS*7 | Alternate function output-enable, same indexing |
| alt_din | output | NUM_PADS | Synchronized, invert-adjusted pad input to alternate functions |
| pad_in | input | NUM_PADS | Raw pad input levels |
| pad_out | output | NUM_PADS | Pad output level |
| pad_oe | output | NUM_PADS | Pad output enable |
| pad_pu | output | NUM_PADS | Pull-up request |
| pad_pd | output | NUM_PADS | Pull-down request |

## Verification
The bench builds the block with its default of 80 pads. With that value the third 32-bit word is only half populated, so the zero-forced upper sixteen bits of the input and latch words can be observed. Setup addresses 0x50 and above also exist in the address space without a backing pad, which exercises the ignored-write path. The highest pad, 79, is checked at the edge of the final word with invert and both pulls set.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

    localparam int DATA_W    = 32;
    localparam int MODE_W    = 3;
    localparam int NUM_MODES = 8;
    localparam int ALT_N     = NUM_MODES - 1;
    localparam int CFG_W     = 7;
    localparam int WIDX_W    = 4;
    localparam logic [MODE_W-1:0] GPIO_MODE = MODE_W'(NUM_MODES - 1);

    typedef struct packed {
        logic              inv;
        logic              pu;
        logic              pd;
        logic              dir;
        logic [MODE_W-1:0] mode;
    } pad_cfg_t;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CFG,
        RG_DIN,
        RG_SET,
        RG_CLR,
        RG_DOUT
    } bus_region_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 80
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;
    logic [1:0]   seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          seen <= '0;
        else if (seen != 2'd2) seen <= seen + 2'd1;
    end

    assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pad_pkg::*;
#(
    parameter int NUM_PADS = 80,
    localparam int NUM_WORDS = (NUM_PADS + DATA_W - 1) / DATA_W,
    localparam int TOT       = NUM_WORDS * DATA_W,
    localparam int PAD_AW    = $clog2(NUM_PADS),
    localparam int ADDR_W    = PAD_AW + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NUM_PADS-1:0]   din_vis,
    output pad_cfg_t [NUM_PADS-1:0] cfg_q,
    output logic [NUM_PADS-1:0]   dout
);

    function automatic logic [TOT-1:0] mk_mask();
        logic [TOT-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_PADS; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] word_of(input logic [TOT-1:0] v,
                                                  input logic [WIDX_W-1:0] i);
        return v[int'(i)*DATA_W +: DATA_W];
    endfunction

    localparam logic [TOT-1:0]    VMASK     = mk_mask();
    localparam logic [PAD_AW-1:0] LAST_PAD  = PAD_AW'(NUM_PADS - 1);
    localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(NUM_WORDS - 1);
    localparam logic [ADDR_W-1:0] BELOW_TOP = {1'b0, {(ADDR_W-1){1'b1}}};
    localparam logic [ADDR_W-1:0] LOW_BITS  = {{(ADDR_W-WIDX_W-2){1'b0}}, {(WIDX_W+2){1'b1}}};
    localparam logic [ADDR_W-1:0] HI_MASK   = BELOW_TOP & ~LOW_BITS;

    bus_region_e       region;
    logic [PAD_AW-1:0] pidx;
    logic [WIDX_W-1:0] widx;
    logic [TOT-1:0]    dout_q;
    logic [TOT-1:0]    din_full;
    logic [DATA_W-1:0] wmask;

    assign pidx = bus_addr[PAD_AW-1:0];
    assign widx = bus_addr[WIDX_W-1:0];

    always_comb begin
        region = RG_NONE;
        if (!bus_addr[ADDR_W-1]) begin
            if (pidx <= LAST_PAD) region = RG_CFG;
        end else if (((bus_addr & HI_MASK) == '0) && (widx <= LAST_WORD)) begin
            unique case (bus_addr[WIDX_W+1:WIDX_W])
                2'd0: region = RG_DIN;
                2'd1: region = RG_SET;
                2'd2: region = RG_CLR;
                2'd3: region = RG_DOUT;
            endcase
        end
    end

    always_comb begin
        wmask = bus_wdata & word_of(VMASK, widx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PADS; i++) begin
                cfg_q[i] <= '{inv: 1'b0, pu: 1'b0, pd: 1'b0, dir: 1'b0, mode: GPIO_MODE};
            end
            dout_q <= '0;
        end else if (bus_we) begin
            unique case (region)
                RG_CFG:  cfg_q[pidx] <= pad_cfg_t'(bus_wdata[CFG_W-1:0]);
                RG_SET:  dout_q[int'(widx)*DATA_W +: DATA_W] <= word_of(dout_q, widx) | wmask;
                RG_CLR:  dout_q[int'(widx)*DATA_W +: DATA_W] <= word_of(dout_q, widx) & ~bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        din_full                 = '0;
        din_full[NUM_PADS-1:0]   = din_vis;
        bus_rdata                = '0;
        unique case (region)
            RG_CFG:  bus_rdata = DATA_W'(cfg_q[pidx]);
            RG_DIN:  bus_rdata = word_of(din_full, widx);
            RG_DOUT: bus_rdata = word_of(dout_q, widx);
            default: bus_rdata = '0;
        endcase
    end

    assign dout = dout_q[NUM_PADS-1:0];

    assert_cfg_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && region == RG_CFG) |=>
            (cfg_q[$past(pidx)] == pad_cfg_t'($past(bus_wdata[CFG_W-1:0]))));

    assert_raise_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && region == RG_SET) |=>
            ((word_of(dout_q, $past(widx)) & $past(wmask)) == $past(wmask)));

    assert_drop_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && region == RG_CLR) |=>
            ((word_of(dout_q, $past(widx)) & $past(bus_wdata)) == '0));

    assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (region == RG_SET || region == RG_CLR)) |=> $stable(dout_q));

    assert_spare_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((dout_q & ~VMASK) == '0));

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_pad_pkg::*;
#(
    parameter int NUM_PADS = 80
) (
    input  pad_cfg_t [NUM_PADS-1:0]    cfg,
    input  logic [NUM_PADS-1:0]        dout,
    input  logic [NUM_PADS*ALT_N-1:0]  alt_dout,
    input  logic [NUM_PADS*ALT_N-1:0]  alt_oe,
    input  logic [NUM_PADS-1:0]        din_sync,
    output logic [NUM_PADS-1:0]        din_vis,
    output logic [NUM_PADS-1:0]        pad_out,
    output logic [NUM_PADS-1:0]        pad_oe,
    output logic [NUM_PADS-1:0]        pad_pu,
    output logic [NUM_PADS-1:0]        pad_pd
);

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        pad_cfg_t         c;
        logic [ALT_N-1:0] ad;
        logic [ALT_N-1:0] ao;
        logic             raw;
        logic             oe;

        assign c  = cfg[p];
        assign ad = alt_dout[p*ALT_N +: ALT_N];
        assign ao = alt_oe[p*ALT_N +: ALT_N];

        always_comb begin
            if (c.mode == GPIO_MODE) begin
                raw = dout[p];
                oe  = c.dir;
            end else begin
                raw = ad[c.mode];
                oe  = ao[c.mode];
            end
        end

        assign pad_out[p] = raw ^ c.inv;
        assign pad_oe[p]  = oe;
        assign pad_pu[p]  = c.pu;
        assign pad_pd[p]  = c.pd & ~c.pu;
        assign din_vis[p] = din_sync[p] ^ c.inv;
    end

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_pad_pkg::*;
#(
    parameter int NUM_PADS = 80,
    localparam int ADDR_W = $clog2(NUM_PADS) + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_PADS*ALT_N-1:0]  alt_dout,
    input  logic [NUM_PADS*ALT_N-1:0]  alt_oe,
    output logic [NUM_PADS-1:0]        alt_din,
    input  logic [NUM_PADS-1:0]        pad_in,
    output logic [NUM_PADS-1:0]        pad_out,
    output logic [NUM_PADS-1:0]        pad_oe,
    output logic [NUM_PADS-1:0]        pad_pu,
    output logic [NUM_PADS-1:0]        pad_pd
);

    pad_cfg_t [NUM_PADS-1:0] cfg;
    logic [NUM_PADS-1:0]     dout;
    logic [NUM_PADS-1:0]     din_sync;
    logic [NUM_PADS-1:0]     din_vis;

    gpio_sync #(.W(NUM_PADS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (din_sync)
    );

    gpio_regfile #(.NUM_PADS(NUM_PADS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .din_vis   (din_vis),
        .cfg_q     (cfg),
        .dout      (dout)
    );

    gpio_pad_mux #(.NUM_PADS(NUM_PADS)) u_mux (
        .cfg      (cfg),
        .dout     (dout),
        .alt_dout (alt_dout),
        .alt_oe   (alt_oe),
        .din_sync (din_sync),
        .din_vis  (din_vis),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .pad_pu   (pad_pu),
        .pad_pd   (pad_pd)
    );

    assign alt_din = din_vis;

    assert_pull_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_pd) == '0));

endmodule

// File: tb/gpio_pad_ctrl_tb.sv
module gpio_pad_ctrl_tb;

    localparam int NP = 80;
    localparam int AN = 7;
    localparam int NV = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP*AN-1:0] alt_dout = '0;
    logic [NP*AN-1:0] alt_oe = '0;
    logic [NP-1:0] alt_din;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, pad_pu, pad_pd;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    gpio_pad_ctrl #(.NUM_PADS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_dout(alt_dout),
        .alt_oe(alt_oe), .alt_din(alt_din), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    // write address, write data, read address, expected read, requirement
    localparam logic [7:0]  V_WA [NV] = '{8'h90, 8'h90, 8'hA0, 8'h92, 8'hA2, 8'h03, 8'h4F, 8'h80, 8'hC0, 8'h50, 8'h93};
    localparam logic [31:0] V_WD [NV] = '{32'h0000_00F0, 32'h0000_0F00, 32'h0000_0030, 32'hFFFF_FFFF,
                                          32'h0000_00FF, 32'h0000_006D, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                          32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
    localparam logic [7:0]  V_RA [NV] = '{8'hB0, 8'hB0, 8'hB0, 8'hB2, 8'hB2, 8'h03, 8'h4F, 8'hB0, 8'hB1, 8'hB0, 8'hB1};
    localparam logic [31:0] V_EX [NV] = '{32'h0000_00F0, 32'h0000_0FF0, 32'h0000_0FC0, 32'h0000_FFFF,
                                          32'h0000_FF00, 32'h0000_006D, 32'h0000_007F, 32'h0000_0FC0,
                                          32'h0000_0000, 32'h0000_0FC0, 32'h0000_0000};
    // R5, R5, R6, R11, R6, R2, R2, R10, R10, R10, R10
    localparam int V_RQ [NV] = '{5, 5, 6, 11, 6, 2, 2, 10, 10, 10, 10};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state at the pad pins while reset is held
        check("R1 oe", 32'(pad_oe != '0), 32'd0);
        check("R1 out", 32'(pad_out != '0), 32'd0);
        check("R1 pulls", 32'((pad_pu | pad_pd) != '0), 32'd0);
        rst_n = 1'b1;
        rd(8'h00, r); check("R1 cfg0", r, 32'h07);
        rd(8'h4F, r); check("R1 cfg79", r, 32'h07);
        rd(8'hB1, r); check("R1 latch", r, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(V_WA[i], V_WD[i]);
            rd(V_RA[i], r);
            check($sformatf("R%0d vec%0d", V_RQ[i], i), r, V_EX[i]);
        end
        rd(8'h50, r); check("R10 unmapped read", r, 32'h0);

        // R4 GPIO mode: pad 6 latch bit is set, direction drive
        wr(8'h06, 32'h0F);
        #1 check("R4 out", 32'(pad_out[6]), 32'd1);
        check("R4 oe", 32'(pad_oe[6]), 32'd1);
        wr(8'hA0, 32'h40);
        #1 check("R4 out cleared", 32'(pad_out[6]), 32'd0);
        wr(8'h06, 32'h07);
        #1 check("R4 oe input", 32'(pad_oe[6]), 32'd0);

        // R3 alternate sources on pad 10
        alt_dout[10*AN+2] = 1'b1; alt_oe[10*AN+2] = 1'b1;
        alt_oe[10*AN+6] = 1'b1;
        wr(8'h0A, 32'h02);
        #1 check("R3 m2 out", 32'(pad_out[10]), 32'd1);
        check("R3 m2 oe", 32'(pad_oe[10]), 32'd1);
        wr(8'h0A, 32'h06);
        #1 check("R3 m6 out", 32'(pad_out[10]), 32'd0);
        check("R3 m6 oe", 32'(pad_oe[10]), 32'd1);

        // R7 invert on output in both modes
        wr(8'h0A, 32'h46);
        #1 check("R7 alt inv", 32'(pad_out[10]), 32'd1);
        wr(8'h06, 32'h4F);
        #1 check("R7 gpio inv", 32'(pad_out[6]), 32'd1);

        // R8 pulls
        wr(8'h14, 32'h17);
        #1 check("R8 pd only", {30'd0, pad_pu[20], pad_pd[20]}, 32'd1);
        check("R8 both set", {30'd0, pad_pu[79], pad_pd[79]}, 32'd2);

        // R7 input invert: pads 3, 6, 10, 79 inverted, pad_in all zero
        rd(8'h80, r); check("R7 din0 inv", r, 32'h0000_0448);
        rd(8'h82, r); check("R9 din2 upper zero", r, 32'h0000_8000);
        check("R7 alt_din", {29'd0, alt_din[6], alt_din[5], alt_din[79]}, 32'd5);

        // R9 synchronizer latency on pad 40 (word 1 bit 8)
        @(negedge clk);
        bus_addr = 8'h81; pad_in[40] = 1'b1;
        @(posedge clk); #2 check("R9 one edge", 32'(bus_rdata[8]), 32'd0);
        @(posedge clk); #2 check("R9 two edges", 32'(bus_rdata[8]), 32'd1);

        // R9 all pads high
        @(negedge clk); pad_in = '1;
        repeat (3) @(negedge clk);
        rd(8'h80, r); check("R9 din0 all", r, 32'hFFFF_FBB7);
        rd(8'h82, r); check("R9 din2 all", r, 32'h0000_7FFF);
        rd(8'h83, r); check("R10 beyond last word", r, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule